// File: doc/BRIEF.md
# Power domain switch sequencer

This block brings one switchable logic domain up and down in a fixed order. It drives the control pins of the domain's power switches, its electrical and functional isolation clamps, and the request pin of an external memory-repair engine. It watches a power-good input and a repair-done input. A one-cycle power-up or power-down request starts a sequence. A busy flag, a done pulse and a sticky error code report how the sequence went.

On power-up the switches close at the smallest inrush-current setting. If power-good does not arrive within a window, the next larger setting is tried. There are four settings in all, and when the last one fails the switches open again and an error is reported. After power-good, the electrical clamp is released and memory repair is requested. When repair completes, the functional clamp is released. If repair times out, the partial sequence is unwound. Power-down applies the clamps and then opens the switches.

Top module: `pwr_dom_seq`

## Requirements
- R1: While reset is asserted and after it: swClose=0, inrushLvl=0, isoElec=1, isoFunc=1, repairReq=0, busy=0, done=0, errCode=0, lockLevel=0 and stateOut=0.
- R2: A power-up request accepted in idle with the switches open gives swClose=1, inrushLvl=0 and busy=1 in the next cycle.
- R3: The sequencer samples power-good for PG_WAIT_CYC cycles at each inrush level. If power-good is absent for that whole window, inrushLvl rises by one and the switches stay closed.
- R4: The cycle after power-good is sampled high, isoElec falls. One cycle later repairReq rises. repairReq is never high while isoElec is 1.
- R5: The cycle after repairDone is sampled high, repairReq falls, isoFunc falls and done pulses.
- R6: If the window at inrush level 3 expires without power-good, the next cycle shows swClose=0, inrushLvl=0, done=1 and errCode=1.
- R7: If repairDone is absent for REP_WAIT_CYC cycles, repairReq falls and isoElec returns to 1. One cycle later swClose=0, inrushLvl=0, done=1 and errCode=2.
- R8: A power-down sets isoFunc=1 in the cycle after acceptance, isoElec=1 in the cycle after that, and swClose=0 with inrushLvl=0 in the cycle after that. done pulses with that last step.
- R9: A power-up request accepted while swClose=1 pulses done in the next cycle and changes no control output.
- R10: Requests are accepted only in idle (busy=0, done=0). busy stays high from the cycle after acceptance until done, done lasts one cycle, and requests made at any other time have no effect. When both requests are present in idle, power-up wins.
- R11: errCode holds its value (0 none, 1 power-good timeout, 2 repair timeout) until the next accepted request clears it.
- R12: lockLevel takes the inrush level at which power-good was sampled. stateOut reads 0 in idle and 7 in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqOn | input | 1 | Power-up request |
| reqOff | input | 1 | Power-down request |
| pwrGood | input | 1 | Supply good indication from the switches |
| repairDone | input | 1 | Memory-repair complete |
| swClose | output | 1 | Close the power switches |
| inrushLvl | output | 2 | Inrush current limit setting |
| isoElec | output | 1 | Electrical isolation applied |
| isoFunc | output | 1 | Functional isolation applied |
| repairReq | output | 1 | Memory-repair request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| errCode | output | 2 | Sticky result code |
| lockLevel | output | 2 | Inrush level at power-good |
| stateOut | output | 4 | Current sequencer state |

## Verification
Power-up is driven with a supply that comes good at level 0, at level 2, and never. The first case shows that no needless ramp occurs, the second exercises stepping through the levels, and the third exercises exhausting them. Memory repair is driven to finish quickly, to finish at once, or never. The last case separates the clean path from the unwind path. Redundant, overlapping and simultaneous requests show that only requests accepted in idle take effect and that power-up has priority.

// File: rtl/pwr_dom_seq_pkg.sv
package pwr_dom_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_PGWAIT  = 4'd1,
    ST_ISOREL  = 4'd2,
    ST_REPWAIT = 4'd3,
    ST_UNWIND  = 4'd4,
    ST_OFFELEC = 4'd5,
    ST_OFFSW   = 4'd6,
    ST_FINISH  = 4'd7
  } seqState_t;

  typedef struct packed {
    logic swCloseSet;
    logic swOpen;
    logic lvlClear;
    logic lvlStep;
    logic tmrClear;
    logic tmrStep;
    logic elecRelease;
    logic elecApply;
    logic funcRelease;
    logic funcApply;
    logic repRaise;
    logic repDrop;
    logic lvlLatch;
    logic errClear;
    logic errPg;
    logic errRep;
  } seqCmd_t;

  localparam logic [1:0] ERR_NONE   = 2'd0;
  localparam logic [1:0] ERR_PGOOD  = 2'd1;
  localparam logic [1:0] ERR_REPAIR = 2'd2;

endpackage

// File: rtl/pwr_dom_seq_dp.sv
module pwr_dom_seq_dp
  import pwr_dom_seq_pkg::*;
#(
  parameter int LVL_W        = 2,
  parameter int PG_WAIT_CYC  = 3000,
  parameter int REP_WAIT_CYC = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCmd_t          cmd,
  output logic             swClose,
  output logic [LVL_W-1:0] inrushLvl,
  output logic             isoElec,
  output logic             isoFunc,
  output logic             repairReq,
  output logic [1:0]       errCode,
  output logic [LVL_W-1:0] lockLevel,
  output logic             lvlMax,
  output logic             pgExpired,
  output logic             repExpired
);

  localparam int MAX_WAIT = (PG_WAIT_CYC > REP_WAIT_CYC) ? PG_WAIT_CYC : REP_WAIT_CYC;
  localparam int TMR_W    = $clog2(MAX_WAIT + 1);
  localparam logic [TMR_W-1:0] PG_LAST  = TMR_W'(PG_WAIT_CYC - 1);
  localparam logic [TMR_W-1:0] REP_LAST = TMR_W'(REP_WAIT_CYC - 1);
  localparam logic [LVL_W-1:0] LVL_TOP  = {LVL_W{1'b1}};

  logic [TMR_W-1:0] waitTmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swClose   <= 1'b0;
      inrushLvl <= '0;
      isoElec   <= 1'b1;
      isoFunc   <= 1'b1;
      repairReq <= 1'b0;
      errCode   <= ERR_NONE;
      lockLevel <= '0;
      waitTmr   <= '0;
    end else begin
      if (cmd.swCloseSet)   swClose <= 1'b1;
      else if (cmd.swOpen)  swClose <= 1'b0;

      if (cmd.lvlClear)     inrushLvl <= '0;
      else if (cmd.lvlStep) inrushLvl <= inrushLvl + 1'b1;

      if (cmd.tmrClear)     waitTmr <= '0;
      else if (cmd.tmrStep) waitTmr <= waitTmr + 1'b1;

      if (cmd.elecRelease)    isoElec <= 1'b0;
      else if (cmd.elecApply) isoElec <= 1'b1;

      if (cmd.funcRelease)    isoFunc <= 1'b0;
      else if (cmd.funcApply) isoFunc <= 1'b1;

      if (cmd.repRaise)     repairReq <= 1'b1;
      else if (cmd.repDrop) repairReq <= 1'b0;

      if (cmd.errClear)     errCode <= ERR_NONE;
      else if (cmd.errPg)   errCode <= ERR_PGOOD;
      else if (cmd.errRep)  errCode <= ERR_REPAIR;

      if (cmd.lvlLatch)     lockLevel <= inrushLvl;
    end
  end

  assign lvlMax     = (inrushLvl == LVL_TOP);
  assign pgExpired  = (waitTmr == PG_LAST);
  assign repExpired = (waitTmr == REP_LAST);

endmodule

// File: rtl/pwr_dom_seq_ctrl.sv
module pwr_dom_seq_ctrl
  import pwr_dom_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqOn,
  input  logic      reqOff,
  input  logic      pwrGood,
  input  logic      repairDone,
  input  logic      swClose,
  input  logic      lvlMax,
  input  logic      pgExpired,
  input  logic      repExpired,
  output seqCmd_t   cmd,
  output seqState_t state,
  output logic      busy,
  output logic      done
);

  seqState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    cmd       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqOn) begin
          cmd.errClear = 1'b1;
          if (swClose) begin
            nextState = ST_FINISH;
          end else begin
            cmd.swCloseSet = 1'b1;
            cmd.lvlClear   = 1'b1;
            cmd.tmrClear   = 1'b1;
            nextState      = ST_PGWAIT;
          end
        end else if (reqOff) begin
          cmd.errClear  = 1'b1;
          cmd.funcApply = 1'b1;
          nextState     = ST_OFFELEC;
        end
      end
      ST_PGWAIT: begin
        if (pwrGood) begin
          cmd.lvlLatch    = 1'b1;
          cmd.elecRelease = 1'b1;
          nextState       = ST_ISOREL;
        end else if (pgExpired) begin
          if (lvlMax) begin
            cmd.swOpen   = 1'b1;
            cmd.lvlClear = 1'b1;
            cmd.errPg    = 1'b1;
            nextState    = ST_FINISH;
          end else begin
            cmd.lvlStep  = 1'b1;
            cmd.tmrClear = 1'b1;
          end
        end else begin
          cmd.tmrStep = 1'b1;
        end
      end
      ST_ISOREL: begin
        cmd.repRaise = 1'b1;
        cmd.tmrClear = 1'b1;
        nextState    = ST_REPWAIT;
      end
      ST_REPWAIT: begin
        if (repairDone) begin
          cmd.repDrop     = 1'b1;
          cmd.funcRelease = 1'b1;
          nextState       = ST_FINISH;
        end else if (repExpired) begin
          cmd.repDrop   = 1'b1;
          cmd.elecApply = 1'b1;
          nextState     = ST_UNWIND;
        end else begin
          cmd.tmrStep = 1'b1;
        end
      end
      ST_UNWIND: begin
        cmd.swOpen   = 1'b1;
        cmd.lvlClear = 1'b1;
        cmd.errRep   = 1'b1;
        nextState    = ST_FINISH;
      end
      ST_OFFELEC: begin
        cmd.elecApply = 1'b1;
        nextState     = ST_OFFSW;
      end
      ST_OFFSW: begin
        cmd.swOpen   = 1'b1;
        cmd.lvlClear = 1'b1;
        nextState    = ST_FINISH;
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE) && (state != ST_FINISH);
  assign done = (state == ST_FINISH);

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_dom_seq_pkg::*;
#(
  parameter int PG_WAIT_CYC  = 3000,
  parameter int REP_WAIT_CYC = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqOn,
  input  logic       reqOff,
  input  logic       pwrGood,
  input  logic       repairDone,
  output logic       swClose,
  output logic [1:0] inrushLvl,
  output logic       isoElec,
  output logic       isoFunc,
  output logic       repairReq,
  output logic       busy,
  output logic       done,
  output logic [1:0] errCode,
  output logic [1:0] lockLevel,
  output logic [3:0] stateOut
);

  seqCmd_t   cmd;
  seqState_t state;
  logic      lvlMax;
  logic      pgExpired;
  logic      repExpired;

  pwr_dom_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqOn      (reqOn),
    .reqOff     (reqOff),
    .pwrGood    (pwrGood),
    .repairDone (repairDone),
    .swClose    (swClose),
    .lvlMax     (lvlMax),
    .pgExpired  (pgExpired),
    .repExpired (repExpired),
    .cmd        (cmd),
    .state      (state),
    .busy       (busy),
    .done       (done)
  );

  pwr_dom_seq_dp #(
    .LVL_W        (2),
    .PG_WAIT_CYC  (PG_WAIT_CYC),
    .REP_WAIT_CYC (REP_WAIT_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .swClose    (swClose),
    .inrushLvl  (inrushLvl),
    .isoElec    (isoElec),
    .isoFunc    (isoFunc),
    .repairReq  (repairReq),
    .errCode    (errCode),
    .lockLevel  (lockLevel),
    .lvlMax     (lvlMax),
    .pgExpired  (pgExpired),
    .repExpired (repExpired)
  );

  assign stateOut = state;

endmodule

// File: rtl/pwr_dom_seq_chk.sv
module pwr_dom_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       swClose,
  input logic [1:0] inrushLvl,
  input logic       isoElec,
  input logic       isoFunc,
  input logic       repairReq,
  input logic       busy,
  input logic       done,
  input logic [1:0] errCode
);

  // R3: the level only steps up by one or returns to zero
  a_r3_level_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(inrushLvl) |-> (inrushLvl == 2'd0) || (inrushLvl == $past(inrushLvl) + 2'd1));

  // R4: repair is never requested under electrical isolation
  a_r4_repair_needs_power: assert property (@(posedge clk) disable iff (!rstN)
    repairReq |-> !isoElec);

  // R5: functional clamp released only on a fully powered domain
  a_r5_func_release_safe: assert property (@(posedge clk) disable iff (!rstN)
    !isoFunc |-> (swClose && !isoElec));

  // R8: electrical clamp is applied only after the functional clamp
  a_r8_elec_after_func: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isoElec) |-> isoFunc);

  // R8: switches open only with both clamps applied
  a_r8_open_clamped: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swClose) |-> (isoElec && isoFunc && !repairReq));

  // R10: busy and done are never high together
  a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R11: a new error code appears only with the completion pulse
  a_r11_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    ((errCode != 2'd0) && !$stable(errCode)) |-> done);

endmodule

bind pwr_dom_seq pwr_dom_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .swClose   (swClose),
  .inrushLvl (inrushLvl),
  .isoElec   (isoElec),
  .isoFunc   (isoFunc),
  .repairReq (repairReq),
  .busy      (busy),
  .done      (done),
  .errCode   (errCode)
);

// File: tb/pwr_dom_seq_tb.sv
module pwr_dom_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PG_CYC     = 8;
  localparam int REP_CYC    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqOn = 1'b0;
  logic reqOff = 1'b0;
  logic pwrGood = 1'b0;
  logic repairDone;
  logic swClose, isoElec, isoFunc, repairReq, busy, done;
  logic [1:0] inrushLvl, errCode, lockLevel;
  logic [3:0] stateOut;

  int nChecks = 0;
  int nFails  = 0;
  int pgNeed  = 9;
  int repNeed = 99;
  int repCnt  = 0;
  int cycles  = 0;
  bit finished = 0;

  // behavioural expectations
  int mSt = 0, mCnt = 0, mInr = 0, mLock = 0, mErr = 0;
  int mSw = 0, mIsoE = 1, mIsoF = 1, mRep = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_dom_seq #(.PG_WAIT_CYC(PG_CYC), .REP_WAIT_CYC(REP_CYC)) u_dut (
    .clk(clk), .rstN(rstN), .reqOn(reqOn), .reqOff(reqOff),
    .pwrGood(pwrGood), .repairDone(repairDone),
    .swClose(swClose), .inrushLvl(inrushLvl), .isoElec(isoElec),
    .isoFunc(isoFunc), .repairReq(repairReq), .busy(busy), .done(done),
    .errCode(errCode), .lockLevel(lockLevel), .stateOut(stateOut)
  );

  // environment: supply comes good once the limit reaches pgNeed
  always @(posedge clk) begin
    pwrGood <= rstN && swClose && (int'(inrushLvl) >= pgNeed);
    if (!repairReq) repCnt <= 0;
    else            repCnt <= repCnt + 1;
  end
  assign repairDone = repairReq && (repCnt >= repNeed);

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  // reference model stepped on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mSt = 0; mCnt = 0; mInr = 0; mLock = 0; mErr = 0;
      mSw = 0; mIsoE = 1; mIsoF = 1; mRep = 0;
    end else begin
      case (mSt)
        0: if (reqOn) begin
             mErr = 0;
             if (mSw == 1) mSt = 7;
             else begin mSw = 1; mInr = 0; mCnt = 0; mSt = 1; end
           end else if (reqOff) begin
             mErr = 0; mIsoF = 1; mSt = 5;
           end
        1: if (pwrGood) begin
             mLock = mInr; mIsoE = 0; mSt = 2;
           end else if (mCnt == PG_CYC - 1) begin
             if (mInr == 3) begin mSw = 0; mInr = 0; mErr = 1; mSt = 7; end
             else begin mInr = mInr + 1; mCnt = 0; end
           end else mCnt = mCnt + 1;
        2: begin mRep = 1; mCnt = 0; mSt = 3; end
        3: if (repairDone) begin
             mRep = 0; mIsoF = 0; mSt = 7;
           end else if (mCnt == REP_CYC - 1) begin
             mRep = 0; mIsoE = 1; mSt = 4;
           end else mCnt = mCnt + 1;
        4: begin mSw = 0; mInr = 0; mErr = 2; mSt = 7; end
        5: begin mIsoE = 1; mSt = 6; end
        6: begin mSw = 0; mInr = 0; mSt = 7; end
        default: mSt = 0;
      endcase
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (cycles > 0 && !finished) begin
      chk("R2 swClose", int'(swClose), mSw);
      chk("R3 inrushLvl", int'(inrushLvl), mInr);
      chk("R4 isoElec", int'(isoElec), mIsoE);
      chk("R4 repairReq", int'(repairReq), mRep);
      chk("R5 isoFunc", int'(isoFunc), mIsoF);
      chk("R10 busy", int'(busy), (mSt != 0 && mSt != 7) ? 1 : 0);
      chk("R10 done", int'(done), (mSt == 7) ? 1 : 0);
      chk("R11 errCode", int'(errCode), mErr);
      chk("R12 lockLevel", int'(lockLevel), mLock);
      chk("R12 stateOut", int'(stateOut), mSt);
    end
  end

  task automatic pulse(input bit on, input bit off);
    @(negedge clk);
    reqOn = on; reqOff = off;
    @(negedge clk);
    reqOn = 1'b0; reqOff = 1'b0;
  endtask

  task automatic waitDone();
    for (int n = 0; n < 200 && !done; n++) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 swClose", int'(swClose), 0);
    chk("R1 isoElec", int'(isoElec), 1);
    chk("R1 isoFunc", int'(isoFunc), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 stateOut", int'(stateOut), 0);
    rstN = 1'b1;

    // power-up, supply good at the lowest level, quick repair
    pgNeed = 0; repNeed = 2;
    pulse(1, 0);
    chk("R2 close", int'(swClose), 1);
    chk("R2 level", int'(inrushLvl), 0);
    chk("R2 busy", int'(busy), 1);
    waitDone();
    chk("R5 isoFunc", int'(isoFunc), 0);
    chk("R5 errCode", int'(errCode), 0);
    chk("R12 lock", int'(lockLevel), 0);
    @(negedge clk);

    // redundant power-up
    pulse(1, 0);
    chk("R9 done", int'(done), 1);
    chk("R9 swClose", int'(swClose), 1);
    chk("R9 isoFunc", int'(isoFunc), 0);
    @(negedge clk);

    // power-down
    pulse(0, 1);
    waitDone();
    chk("R8 swClose", int'(swClose), 0);
    chk("R8 isoElec", int'(isoElec), 1);
    chk("R8 isoFunc", int'(isoFunc), 1);
    @(negedge clk);

    // ramp to level 2, power-down request during the sequence
    pgNeed = 2; repNeed = 1;
    pulse(1, 0);
    repeat (3) @(negedge clk);
    pulse(0, 1);
    waitDone();
    chk("R3 lock", int'(lockLevel), 2);
    chk("R10 ignored off", int'(swClose), 1);
    chk("R10 ignored off func", int'(isoFunc), 0);
    @(negedge clk);
    pulse(0, 1);
    waitDone();
    @(negedge clk);

    // supply never good
    pgNeed = 9;
    pulse(1, 0);
    waitDone();
    chk("R6 errCode", int'(errCode), 1);
    chk("R6 swClose", int'(swClose), 0);
    chk("R6 level", int'(inrushLvl), 0);
    repeat (4) @(negedge clk);
    chk("R11 sticky", int'(errCode), 1);

    // repair never finishes
    pgNeed = 1; repNeed = 99;
    pulse(1, 0);
    chk("R11 cleared", int'(errCode), 0);
    waitDone();
    chk("R7 errCode", int'(errCode), 2);
    chk("R7 swClose", int'(swClose), 0);
    chk("R7 isoElec", int'(isoElec), 1);
    chk("R7 repairReq", int'(repairReq), 0);
    @(negedge clk);

    // both requests together
    pgNeed = 0; repNeed = 0;
    pulse(1, 1);
    waitDone();
    chk("R10 priority", int'(swClose), 1);
    chk("R10 priority func", int'(isoFunc), 0);
    @(negedge clk);

    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

endmodule